// File: doc/BRIEF.md
# Multi-Function GPIO Port Pin Multiplexer

This block is one port of general-purpose I/O pins. Each pin owns a bit in six writable registers: output value, direction, resistor enable, two source-select bits and an LCD segment enable. The two select bits decide, per pin, whether the pad is steered by the port's own registers or by one of three on-chip peripheral modules. The choice covers both the data driven onto the pad and the direction. For every pin, a build-time mask decides whether a module controls the direction itself or only supplies the data while the direction register keeps control.

Toward the pad the block produces output data, output enable, pull-up enable, pull-down enable and an LCD segment override. The pad input passes through a two-flop synchronizer. Software reads it as the input register. It also fans out to the modules: each module sees the OR of the synchronized inputs of every pin currently routed to it. The block uses no state machine. All of its behaviour is register state plus combinational steering.

Top module: `gpiomux_top`

## Requirements
- R1: Registers are written on a rising clock edge when `wr_en` is high, at these addresses: 0 output, 1 direction, 2 resistor enable, 3 select bit 0, 4 select bit 1, 5 LCD enable. `rd_data` returns the register at `rd_addr` combinationally. Address 6 reads the input register, and address 7 reads 0.
- R2: The per-pin code {sel1,sel0} chooses the pad data. 00 takes the output register. 01 takes module 1 (`mod_dout[W-1:0]`). 10 takes module 2 (`mod_dout[2W-1:W]`). 11 takes module 3 (`mod_dout[3W-1:2W]`).
- R3: With code 00, the direction comes from the direction register. With a module code, it comes from that module's `mod_oe` slice (same layout as `mod_dout`) if the pin's bit in parameter `MOD_DIR` is 1, and from the direction register if that bit is 0.
- R4: A resulting direction of 1 drives `pad_oe` high (output). A direction of 0 leaves it low (input).
- R5: When the resistor enable is 1 and the direction is 0, the output register bit picks the pull: 1 gives `pad_pu`, 0 gives `pad_pd`. Otherwise both pulls are 0, and they are never both 1.
- R6: When a pin's LCD enable is 1, `pad_lcd` is 1 and `pad_oe`, `pad_out`, `pad_pu` and `pad_pd` are 0 for that pin.
- R7: The input register bit equals `pad_in` as sampled two rising edges earlier, and reads 0 while the pin's LCD enable is 1.
- R8: `mod_din[m]` is the OR of the synchronized inputs of all pins whose code selects module m+1 and whose LCD enable is 0.
- R9: After reset, all registers are 0, so every pin is an input with no pull and no LCD override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | W | Write data, one bit per pin |
| rd_addr | input | 3 | Read address |
| rd_data | output | W | Read data |
| mod_dout | input | 3*W | Module data toward pins, module-major |
| mod_oe | input | 3*W | Module direction toward pins, module-major |
| mod_din | output | 3 | Combined input to each module |
| pad_in | input | W | Raw pad input |
| pad_out | output | W | Pad output data |
| pad_oe | output | W | Pad driver enable |
| pad_pu | output | W | Pull-up enable |
| pad_pd | output | W | Pull-down enable |
| pad_lcd | output | W | LCD segment override |

## Verification
The synchronizer property assumes `pad_in` is sampled cleanly at the clock edge. It also assumes two rising edges have passed since reset before the input register is compared. The module-input property assumes nothing about the module signals. The bench changes `pad_in`, module signals and register writes only on falling edges, and holds `pad_in` steady for at least two rising edges before it reads the input register or `mod_din`. The sweep covers every select code together with every setting of output, direction, resistor, LCD and module patterns. The module patterns differ per module, so a crossed module index shows up in the outputs.

// File: rtl/gpiomux_pkg.sv
package gpiomux_pkg;
    localparam int NMOD = 3;

    typedef enum logic [1:0] {
        SRC_PORT = 2'b00,
        SRC_MOD1 = 2'b01,
        SRC_MOD2 = 2'b10,
        SRC_MOD3 = 2'b11
    } src_e;

    typedef enum logic [2:0] {
        A_OUT  = 3'd0,
        A_DIR  = 3'd1,
        A_REN  = 3'd2,
        A_SEL0 = 3'd3,
        A_SEL1 = 3'd4,
        A_LCD  = 3'd5,
        A_IN   = 3'd6,
        A_NONE = 3'd7
    } addr_e;
endpackage

// File: rtl/gpiomux_regs.sv
module gpiomux_regs
    import gpiomux_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] out_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] ren_q,
    output logic [W-1:0] sel0_q,
    output logic [W-1:0] sel1_q,
    output logic [W-1:0] lcd_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            ren_q  <= '0;
            sel0_q <= '0;
            sel1_q <= '0;
            lcd_q  <= '0;
        end else if (wr_en) begin
            unique case (addr_e'(wr_addr))
                A_OUT:   out_q  <= wr_data;
                A_DIR:   dir_q  <= wr_data;
                A_REN:   ren_q  <= wr_data;
                A_SEL0:  sel0_q <= wr_data;
                A_SEL1:  sel1_q <= wr_data;
                A_LCD:   lcd_q  <= wr_data;
                A_IN, A_NONE: ;
            endcase
        end
    end
endmodule

// File: rtl/gpiomux_sync.sv
module gpiomux_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpiomux_pin.sv
module gpiomux_pin
    import gpiomux_pkg::*;
#(
    parameter bit MOD_DIR_BIT = 1'b1
) (
    input  logic [1:0]      sel,
    input  logic            out_bit,
    input  logic            dir_bit,
    input  logic            ren_bit,
    input  logic            lcd_bit,
    input  logic [NMOD-1:0] mdout,
    input  logic [NMOD-1:0] moe,
    input  logic            sync_in,
    output logic            pad_out,
    output logic            pad_oe,
    output logic            pad_pu,
    output logic            pad_pd,
    output logic            in_bit,
    output logic [NMOD-1:0] route
);
    logic data_src;
    logic dir_src;
    logic pull_on;

    always_comb begin
        route = '0;
        unique case (src_e'(sel))
            SRC_PORT: begin
                data_src = out_bit;
                dir_src  = dir_bit;
            end
            SRC_MOD1: begin
                data_src = mdout[0];
                dir_src  = MOD_DIR_BIT ? moe[0] : dir_bit;
                route[0] = sync_in;
            end
            SRC_MOD2: begin
                data_src = mdout[1];
                dir_src  = MOD_DIR_BIT ? moe[1] : dir_bit;
                route[1] = sync_in;
            end
            SRC_MOD3: begin
                data_src = mdout[2];
                dir_src  = MOD_DIR_BIT ? moe[2] : dir_bit;
                route[2] = sync_in;
            end
        endcase
        if (lcd_bit) route = '0;
    end

    assign pull_on = ren_bit & ~dir_src & ~lcd_bit;
    assign pad_oe  = dir_src & ~lcd_bit;
    assign pad_out = data_src & ~lcd_bit;
    assign pad_pu  = pull_on & out_bit;
    assign pad_pd  = pull_on & ~out_bit;
    assign in_bit  = sync_in & ~lcd_bit;
endmodule

// File: rtl/gpiomux_top.sv
module gpiomux_top
    import gpiomux_pkg::*;
#(
    parameter int           W       = 8,
    parameter logic [W-1:0] MOD_DIR = 8'h0F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [W-1:0]    wr_data,
    input  logic [2:0]      rd_addr,
    output logic [W-1:0]    rd_data,
    input  logic [3*W-1:0]  mod_dout,
    input  logic [3*W-1:0]  mod_oe,
    output logic [2:0]      mod_din,
    input  logic [W-1:0]    pad_in,
    output logic [W-1:0]    pad_out,
    output logic [W-1:0]    pad_oe,
    output logic [W-1:0]    pad_pu,
    output logic [W-1:0]    pad_pd,
    output logic [W-1:0]    pad_lcd
);
    logic [W-1:0] out_q, dir_q, ren_q, sel0_q, sel1_q, lcd_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] in_q;
    logic [NMOD-1:0] route [W];

    gpiomux_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_q(out_q), .dir_q(dir_q), .ren_q(ren_q),
        .sel0_q(sel0_q), .sel1_q(sel1_q), .lcd_q(lcd_q)
    );

    gpiomux_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
    );

    for (genvar p = 0; p < W; p++) begin : g_pin
        gpiomux_pin #(.MOD_DIR_BIT(MOD_DIR[p])) u_pin (
            .sel     ({sel1_q[p], sel0_q[p]}),
            .out_bit (out_q[p]),
            .dir_bit (dir_q[p]),
            .ren_bit (ren_q[p]),
            .lcd_bit (lcd_q[p]),
            .mdout   ({mod_dout[2*W+p], mod_dout[W+p], mod_dout[p]}),
            .moe     ({mod_oe[2*W+p], mod_oe[W+p], mod_oe[p]}),
            .sync_in (sync_q[p]),
            .pad_out (pad_out[p]),
            .pad_oe  (pad_oe[p]),
            .pad_pu  (pad_pu[p]),
            .pad_pd  (pad_pd[p]),
            .in_bit  (in_q[p]),
            .route   (route[p])
        );
    end

    assign pad_lcd = lcd_q;

    always_comb begin
        mod_din = '0;
        for (int p = 0; p < W; p++) mod_din = mod_din | route[p];
    end

    always_comb begin
        unique case (addr_e'(rd_addr))
            A_OUT:  rd_data = out_q;
            A_DIR:  rd_data = dir_q;
            A_REN:  rd_data = ren_q;
            A_SEL0: rd_data = sel0_q;
            A_SEL1: rd_data = sel1_q;
            A_LCD:  rd_data = lcd_q;
            A_IN:   rd_data = in_q;
            A_NONE: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gpiomux_chk.sv
module gpiomux_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [2:0]   wr_addr,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] pad_in,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_pu,
    input logic [W-1:0] pad_pd,
    input logic [W-1:0] pad_lcd,
    input logic [2:0]   mod_din,
    input logic [W-1:0] out_q,
    input logic [W-1:0] lcd_q,
    input logic [W-1:0] sel0_q,
    input logic [W-1:0] sel1_q,
    input logic [W-1:0] in_q
);
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    p_write_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> (out_q == $past(wr_data)));

    p_write_lcd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd5) |=> (pad_lcd == $past(wr_data)));

    p_pull_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_pd) == '0) && (((pad_pu | pad_pd) & pad_oe) == '0));

    p_lcd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_lcd & (pad_oe | pad_pu | pad_pd)) == '0));

    p_in_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (in_q == ($past(pad_in, 2) & ~lcd_q)));

    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |-> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0));

    for (genvar m = 0; m < 3; m++) begin : g_mod
        logic [1:0] code;
        assign code = 2'(m + 1);
        logic [W-1:0] hit;
        for (genvar p = 0; p < W; p++) begin : g_p
            assign hit[p] = ({sel1_q[p], sel0_q[p]} == code) && !lcd_q[p];
        end
        p_moddin_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
            mod_din[m] |-> (hit != '0));
    end
endmodule

bind gpiomux_top gpiomux_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pad_in(pad_in), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_lcd(pad_lcd), .mod_din(mod_din), .out_q(out_q),
    .lcd_q(lcd_q), .sel0_q(sel0_q), .sel1_q(sel1_q), .in_q(in_q)
);

// File: tb/sim_gpiomux_top.sv
module sim_gpiomux_top;
    localparam int W = 8;
    localparam logic [W-1:0] MD = 8'h0F;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [W-1:0] wr_data = '0, rd_data, pad_in = '0;
    logic [3*W-1:0] mod_dout = '0, mod_oe = '0;
    logic [2:0] mod_din;
    logic [W-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_lcd;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [W-1:0] s_out = 0, s_dir = 0, s_ren = 0, s_sel0 = 0, s_sel1 = 0, s_lcd = 0;
    logic [W-1:0] e_out, e_oe, e_pu, e_pd;

    always #5 clk = ~clk;

    gpiomux_top #(.W(W), .MOD_DIR(MD)) u0 (.*);

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        case (a)
            0: s_out = d;  1: s_dir = d;  2: s_ren = d;
            3: s_sel0 = d; 4: s_sel1 = d; 5: s_lcd = d;
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, string tag, logic [W-1:0] exp);
        rd_addr = 3'(a);
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic model();
        for (int p = 0; p < W; p++) begin
            int code;
            logic d, o, pull;
            code = {s_sel1[p], s_sel0[p]};
            if (code == 0) begin d = s_out[p]; o = s_dir[p]; end
            else begin
                d = mod_dout[(code-1)*W + p];
                o = MD[p] ? mod_oe[(code-1)*W + p] : s_dir[p];
            end
            pull = s_ren[p] & ~o & ~s_lcd[p];
            e_out[p] = d & ~s_lcd[p];
            e_oe[p]  = o & ~s_lcd[p];
            e_pu[p]  = pull & s_out[p];
            e_pd[p]  = pull & ~s_out[p];
        end
    endtask

    task automatic check_pads();
        model();
        chk("R2 pad_out", pad_out, e_out);
        chk("R3/R4 pad_oe", pad_oe, e_oe);
        chk("R5 pad_pu", pad_pu, e_pu);
        chk("R5 pad_pd", pad_pd, e_pd);
        chk("R6 pad_lcd", pad_lcd, s_lcd);
    endtask

    task automatic check_inputs(logic [W-1:0] pin);
        logic [2:0] em;
        @(negedge clk); pad_in = pin;
        @(negedge clk); @(negedge clk);
        rd(6, "R7 input register", pin & ~s_lcd);
        em = '0;
        for (int p = 0; p < W; p++) begin
            int code;
            code = {s_sel1[p], s_sel0[p]};
            if (code != 0 && !s_lcd[p] && pin[p]) em[code-1] = 1'b1;
        end
        chk("R8 mod_din", {5'b0, mod_din}, {5'b0, em});
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 pad_oe", pad_oe, '0);
        chk("R9 pad_pu|pad_pd", pad_pu | pad_pd, '0);
        chk("R9 pad_lcd", pad_lcd, '0);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) rd(a, "R9/R1 reset read", '0);

        // R1: write/readback each register
        for (int a = 0; a < 6; a++) begin
            wr(a, 8'(8'h11 * (a + 3)));
            rd(a, "R1 readback", 8'(8'h11 * (a + 3)));
        end
        wr(7, 8'hFF);
        rd(7, "R1 unused address", '0);
        for (int a = 0; a < 6; a++) wr(a, '0);

        // Exhaustive per-pin combination sweep (R2..R6)
        for (int c = 0; c < 256; c++) begin
            @(negedge clk);
            mod_dout = c[6] ? {8'hF0, 8'h3C, 8'h5A} : {8'h0F, 8'hC3, 8'hA5};
            mod_oe   = c[7] ? {8'h0F, 8'hCC, 8'h96} : {8'hF0, 8'h33, 8'h69};
            wr(0, {W{c[2]}});
            wr(1, {W{c[3]}});
            wr(2, {W{c[4]}});
            wr(3, {W{c[0]}});
            wr(4, {W{c[1]}});
            wr(5, {W{c[5]}});
            check_pads();
        end

        // Mixed per-pin select codes (R2, R3, R8)
        wr(5, 8'h00); wr(3, 8'hAA); wr(4, 8'hCC);
        wr(1, 8'h33); wr(2, 8'hFF); wr(0, 8'h0F);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            mod_dout = {8'(8'h1D * (k + 1)), 8'(8'h37 * (k + 2)), 8'(8'h59 * (k + 3))};
            mod_oe   = ~mod_dout;
            #1 check_pads();
        end

        // Input synchronizer and module fan-in (R7, R8)
        for (int p = 0; p < W; p++) check_inputs(8'(1 << p));
        check_inputs(8'h00);
        check_inputs(8'hFF);
        wr(5, 8'h81);
        check_pads();
        check_inputs(8'hFF);
        check_inputs(8'h81);
        wr(5, 8'h00);
        wr(3, 8'h00); wr(4, 8'h00);
        check_inputs(8'hFF);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule